// File: doc/BRIEF.md
# Integer Instruction Sequencer for a Memory-to-Memory Processor

This block is the control and integer-execution core of a small application-specific processor whose operands live in data memory, not in registers. It reads 32-bit instruction words from an external 256-entry program memory. It splits the 6-bit opcode into a group, a category and a member field. It fetches a second word for the branch formats. It then runs the integer move, compare, branch, call/return and arithmetic subset against an external 256-entry, 16-bit data memory, which has two combinational read ports and one write port.

Every instruction takes exactly three clocks. The sequencer has three states. `S_FETCH` latches the first word from the program counter address. `S_EXT` presents the next address and latches a second word when the opcode needs one. `S_EXEC` reads operands, writes at most one result and updates the program counter. The transitions run FETCH→EXT, EXT→EXEC and EXEC→FETCH unconditionally. Subroutine return addresses go on an internal 8-entry stack. Opcodes outside the subset are skipped and recorded in a sticky flag.

Top module: `isq_core`

## Requirements
- R1: While reset (synchronous, active high) is held and in the first clock after it, the program address is 0, no data write is issued, and both sticky flags read 0.
- R2: Each instruction takes three clocks. A data write, if any, happens only on the third clock, and two writes are always at least three clocks apart. On the second clock the program address is PC+1.
- R3: Opcode bits [31:26] decode as group [31:30], category [29] and member [28:26]. Group 00, category 0 holds members 0..7 = COPY reg, COPY const, NEG, BRANCH reg, BRANCH const, COMPARE, CALL, RETURN. Group 01, category 0 holds members 0..5 = ADD reg, ADD const, SUB reg, SUB const, MUL reg, MUL const.
- R4: The register-form word carries the destination pointer in [25:16] and the source pointer in [15:6]. COPY writes mem[s] and NEG writes −mem[s]. ADD/SUB/MUL write mem[d] op mem[s] in 16-bit two's complement, wrapping, and MUL keeps the low 16 bits. The program counter then advances by 1.
- R5: The constant-form word carries the destination in [25:16] and a 16-bit constant in [15:0]. COPY, ADD, SUB and MUL use that constant in place of mem[s].
- R6: COMPARE writes 0xFFFF, 0x0000 or 0x0001 to the destination when signed mem[d] is less than, equal to or greater than signed mem[s].
- R7: A branch is two words. The second word holds the condition in [31:28], the target pointer in [27:18] and a constant in [15:0]. Conditions are 0 always, 1 equal, 2 not equal, 3 signed less, 4 signed greater-or-equal, and any other code never. The comparison is mem[d] against the constant (const form) or against mem[target] (reg form). When taken, PC = target[7:0]; otherwise PC advances by 2.
- R8: Only the low 8 bits of any 10-bit pointer are used; the upper 2 bits have no effect.
- R9: CALL pushes PC+1 and jumps to the destination pointer's low 8 bits. RETURN pops into PC. Returns are taken in last-in first-out order for up to 8 nested calls.
- R10: A CALL with 8 entries already stacked, or a RETURN with none, sets a stack-error flag that stays set until reset. A failed RETURN advances PC by 1.
- R11: Any other opcode writes nothing, advances PC by 1 and sets an unimplemented flag that stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr_o | output | 8 | Program memory address |
| pm_rdata_i | input | 32 | Program memory read word |
| dm_raddr_a_o | output | 8 | Data read port A address (destination operand) |
| dm_rdata_a_i | input | 16 | Data read port A value |
| dm_raddr_b_o | output | 8 | Data read port B address (source or branch-target operand) |
| dm_rdata_b_i | input | 16 | Data read port B value |
| dm_we_o | output | 1 | Data write enable |
| dm_waddr_o | output | 8 | Data write address |
| dm_wdata_o | output | 16 | Data write value |
| unimpl_o | output | 1 | Sticky unimplemented-opcode flag |
| stk_err_o | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The arithmetic sweep crosses signed extremes (0x7FFF, 0x8000, −1) so that a design with an unsigned COMPARE, a missing wrap or a carried-out MUL writes wrong words. The branch sweep covers every condition code with operands below, equal to and above each other. A flipped comparison, a wrong not-taken step of 1 instead of 2, or an untruncated target sends execution to the wrong marker instruction. Nested calls check LIFO order. Calling past depth 8 and returning on an empty stack check the sticky error and the skip of a failed return. Bad opcodes in each unused group and member must leave their destination word untouched.

// File: rtl/isq_pkg.sv
package isq_pkg;

    typedef enum logic [1:0] {
        S_FETCH = 2'd0,
        S_EXT   = 2'd1,
        S_EXEC  = 2'd2
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_COPY_R, OP_COPY_K, OP_NEG,   OP_BR_R,
        OP_BR_K,   OP_CMP,    OP_CALL,  OP_RET,
        OP_ADD_R,  OP_ADD_K,  OP_SUB_R, OP_SUB_K,
        OP_MUL_R,  OP_MUL_K,  OP_BAD
    } iop_e;

    localparam logic [1:0] GRP_MOVE  = 2'b00;
    localparam logic [1:0] GRP_ARITH = 2'b01;

endpackage

// File: rtl/isq_decode.sv
module isq_decode
    import isq_pkg::*;
(
    input  logic [5:0] opc,
    output iop_e       op,
    output logic       two_word,
    output logic       bad
);
    logic [1:0] grp;
    logic       cat;
    logic [2:0] mbr;

    assign grp = opc[5:4];
    assign cat = opc[3];
    assign mbr = opc[2:0];

    always_comb begin
        op = OP_BAD;
        if (!cat && grp == GRP_MOVE) begin
            case (mbr)
                3'd0: op = OP_COPY_R;
                3'd1: op = OP_COPY_K;
                3'd2: op = OP_NEG;
                3'd3: op = OP_BR_R;
                3'd4: op = OP_BR_K;
                3'd5: op = OP_CMP;
                3'd6: op = OP_CALL;
                default: op = OP_RET;
            endcase
        end else if (!cat && grp == GRP_ARITH) begin
            case (mbr)
                3'd0: op = OP_ADD_R;
                3'd1: op = OP_ADD_K;
                3'd2: op = OP_SUB_R;
                3'd3: op = OP_SUB_K;
                3'd4: op = OP_MUL_R;
                3'd5: op = OP_MUL_K;
                default: op = OP_BAD;
            endcase
        end
    end

    assign two_word = (op == OP_BR_R) || (op == OP_BR_K);
    assign bad      = (op == OP_BAD);
endmodule

// File: rtl/isq_alu.sv
module isq_alu
    import isq_pkg::*;
#(
    parameter int DW = 16
) (
    input  iop_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] k1,
    input  logic [DW-1:0] k2,
    input  logic [3:0]    cond,
    output logic [DW-1:0] res,
    output logic          wr,
    output logic          taken
);
    logic [DW-1:0] cb;

    assign cb = (op == OP_BR_R) ? b : k2;

    always_comb begin
        case (cond)
            4'd0:    taken = 1'b1;
            4'd1:    taken = (a == cb);
            4'd2:    taken = (a != cb);
            4'd3:    taken = ($signed(a) <  $signed(cb));
            4'd4:    taken = ($signed(a) >= $signed(cb));
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        wr  = 1'b1;
        res = '0;
        case (op)
            OP_COPY_R: res = b;
            OP_COPY_K: res = k1;
            OP_NEG:    res = -b;
            OP_CMP: begin
                if ($signed(a) < $signed(b))  res = '1;
                else if (a == b)              res = '0;
                else                          res = DW'(1);
            end
            OP_ADD_R:  res = a + b;
            OP_ADD_K:  res = a + k1;
            OP_SUB_R:  res = a - b;
            OP_SUB_K:  res = a - k1;
            OP_MUL_R:  res = a * b;
            OP_MUL_K:  res = a * k1;
            default:   wr  = 1'b0;
        endcase
    end
endmodule

// File: rtl/isq_rstack.sv
module isq_rstack #(
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] slot [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] top_i;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign top_i = cnt - CW'(1);
    assign dout  = slot[top_i[IW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) slot[cnt[IW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (push && !full)  cnt <= cnt + CW'(1);
        else if (pop && !empty)  cnt <= cnt - CW'(1);
    end

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    a_r9_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !full) |=> (cnt == $past(cnt) + CW'(1)));
    a_r10_full_push_holds: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> full);
endmodule

// File: rtl/isq_core.sv
module isq_core
    import isq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int IW    = 32,
    parameter int PW    = 10,
    parameter int STK_D = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] pm_addr_o,
    input  logic [IW-1:0] pm_rdata_i,
    output logic [AW-1:0] dm_raddr_a_o,
    input  logic [DW-1:0] dm_rdata_a_i,
    output logic [AW-1:0] dm_raddr_b_o,
    input  logic [DW-1:0] dm_rdata_b_i,
    output logic          dm_we_o,
    output logic [AW-1:0] dm_waddr_o,
    output logic [DW-1:0] dm_wdata_o,
    output logic          unimpl_o,
    output logic          stk_err_o
);
    localparam int OPW   = 6;
    localparam int OP_LO = IW - OPW;
    localparam int D_LO  = OP_LO - PW;
    localparam int S_LO  = D_LO - PW;
    localparam int C_LO  = IW - 4;
    localparam int T_LO  = C_LO - PW;

    seq_state_e    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [IW-1:0] ir_q, ir2_q;
    logic          unimpl_q, err_q;

    iop_e          op;
    logic          two_word, bad;
    logic [PW-1:0] dptr, sptr, tptr;
    logic [DW-1:0] k1, k2, res;
    logic [3:0]    cond;
    logic          wr, taken;
    logic          in_exec, push, pop, stk_fault;
    logic [AW-1:0] stk_top;
    logic          stk_full, stk_empty;

    assign dptr = ir_q[D_LO +: PW];
    assign sptr = ir_q[S_LO +: PW];
    assign k1   = ir_q[DW-1:0];
    assign cond = ir2_q[C_LO +: 4];
    assign tptr = ir2_q[T_LO +: PW];
    assign k2   = ir2_q[DW-1:0];
    assign in_exec = (state_q == S_EXEC);

    isq_decode u_dec (
        .opc      (ir_q[OP_LO +: OPW]),
        .op       (op),
        .two_word (two_word),
        .bad      (bad)
    );

    isq_alu #(.DW(DW)) u_alu (
        .op    (op),
        .a     (dm_rdata_a_i),
        .b     (dm_rdata_b_i),
        .k1    (k1),
        .k2    (k2),
        .cond  (cond),
        .res   (res),
        .wr    (wr),
        .taken (taken)
    );

    isq_rstack #(.DEPTH(STK_D), .AW(AW)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (pc_q + AW'(1)),
        .dout  (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Next state: fixed three-clock instruction cycle.
    always_comb begin
        unique case (state_q)
            S_FETCH: state_d = S_EXT;
            S_EXT:   state_d = S_EXEC;
            S_EXEC:  state_d = S_FETCH;
            default: state_d = S_FETCH;
        endcase
    end

    // Program-counter selection and stack control for the execute clock.
    always_comb begin
        pc_d      = pc_q + AW'(1);
        push      = 1'b0;
        pop       = 1'b0;
        stk_fault = 1'b0;
        case (op)
            OP_BR_R, OP_BR_K: pc_d = taken ? tptr[AW-1:0] : pc_q + AW'(2);
            OP_CALL: begin
                pc_d      = dptr[AW-1:0];
                push      = in_exec;
                stk_fault = stk_full;
            end
            OP_RET: begin
                pop = in_exec;
                if (stk_empty) stk_fault = 1'b1;
                else           pc_d      = stk_top;
            end
            default: ;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_FETCH;
            pc_q     <= '0;
            ir_q     <= '0;
            ir2_q    <= '0;
            unimpl_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_FETCH: ir_q <= pm_rdata_i;
                S_EXT:   if (two_word) ir2_q <= pm_rdata_i;
                S_EXEC: begin
                    pc_q <= pc_d;
                    if (bad)       unimpl_q <= 1'b1;
                    if (stk_fault) err_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Output process.
    always_comb begin
        pm_addr_o    = (state_q == S_EXT) ? pc_q + AW'(1) : pc_q;
        dm_raddr_a_o = dptr[AW-1:0];
        dm_raddr_b_o = (op == OP_BR_R) ? tptr[AW-1:0] : sptr[AW-1:0];
        dm_we_o      = in_exec && wr;
        dm_waddr_o   = dptr[AW-1:0];
        dm_wdata_o   = res;
        unimpl_o     = unimpl_q;
        stk_err_o    = err_q;
    end

    a_r2_write_spacing: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |=> (!dm_we_o ##1 !dm_we_o));
    a_r2_pc_only_in_exec: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_EXEC) |=> $stable(pc_q));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        stk_err_o |=> stk_err_o);
    a_r11_unimpl_sticky: assert property (@(posedge clk) disable iff (rst)
        unimpl_o |=> unimpl_o);
    a_r11_bad_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_exec && bad) |-> !dm_we_o);
endmodule

// File: tb/isq_core_test.sv
`timescale 1ns/1ps
module isq_core_test;
    localparam logic [5:0] O_COPY_R = 6'b000000, O_COPY_K = 6'b000001, O_NEG = 6'b000010,
                           O_BR_R = 6'b000011, O_BR_K = 6'b000100, O_CMP = 6'b000101,
                           O_CALL = 6'b000110, O_RET = 6'b000111,
                           O_ADD_R = 6'b010000, O_ADD_K = 6'b010001, O_SUB_R = 6'b010010,
                           O_SUB_K = 6'b010011, O_MUL_R = 6'b010100, O_MUL_K = 6'b010101;
    localparam logic [15:0] AV [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002,
                                       16'h7FFF, 16'h8000, 16'h1234, 16'hFF00};
    localparam logic [15:0] BV [3] = '{16'hFFFE, 16'h0000, 16'h0003};
    localparam logic [5:0]  BADOP [5] = '{6'b100000, 6'b110101, 6'b001000, 6'b011000, 6'b010110};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pm_addr, ra, rb, wa;
    logic [31:0] pm_rdata;
    logic [15:0] rda, rdb, wd;
    logic        we, unimpl, stk_err;
    logic [31:0] pmem [256];
    logic [15:0] dmem [256];
    int          total = 0, fail = 0, wcnt = 0;

    always #10 clk = ~clk;

    assign pm_rdata = pmem[pm_addr];
    assign rda      = dmem[ra];
    assign rdb      = dmem[rb];

    always @(posedge clk) begin
        if (we) dmem[wa] <= wd;
        if (rst) wcnt <= 0;
        else if (we) wcnt <= wcnt + 1;
    end

    isq_core uut (
        .clk(clk), .rst(rst), .pm_addr_o(pm_addr), .pm_rdata_i(pm_rdata),
        .dm_raddr_a_o(ra), .dm_rdata_a_i(rda), .dm_raddr_b_o(rb), .dm_rdata_b_i(rdb),
        .dm_we_o(we), .dm_waddr_o(wa), .dm_wdata_o(wd),
        .unimpl_o(unimpl), .stk_err_o(stk_err)
    );

    function automatic logic [31:0] w_rr(logic [5:0] o, logic [9:0] d, logic [9:0] s);
        return {o, d, s, 6'b0};
    endfunction
    function automatic logic [31:0] w_rc(logic [5:0] o, logic [9:0] d, logic [15:0] k);
        return {o, d, k};
    endfunction
    function automatic logic [31:0] w_ext(logic [3:0] c, logic [9:0] t, logic [15:0] k);
        return {c, t, 2'b00, k};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear();
        for (int i = 0; i < 256; i++) begin pmem[i] = 32'h0; dmem[i] = 16'h0; end
    endtask

    task automatic start();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic run(int n);
        start();
        repeat (3 * n) @(posedge clk);
        #1;
    endtask

    task automatic self_loop(int at);
        pmem[at]     = w_rc(O_BR_K, 10'd0, 16'h0);
        pmem[at + 1] = w_ext(4'd0, 10'(at), 16'h0);
    endtask

    initial begin
        #3_000_000;
        total++; fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

    initial begin
        // R1: reset state
        clear();
        @(negedge clk);
        chk("R1 addr in reset", 32'(pm_addr), 0);
        chk("R1 we in reset", 32'(we), 0);
        start();
        chk("R1 addr after reset", 32'(pm_addr), 0);
        chk("R1 flags after reset", {30'b0, unimpl, stk_err}, 0);

        // R2: write lands on third clock, second clock addresses PC+1
        clear();
        pmem[0] = w_rc(O_COPY_K, 10'd2, 16'h00AB);
        start();
        @(posedge clk); #1;
        chk("R2 addr clock 2", 32'(pm_addr), 1);
        @(posedge clk); #1;
        chk("R2 no write before clock 3", 32'(dmem[2]), 0);
        @(posedge clk); #1;
        chk("R2 write at clock 3", 32'(dmem[2]), 32'h00AB);

        // R3 R4 R5 R6 R8: arithmetic sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] a, b, c;
                a = AV[i]; b = AV[j];
                clear();
                dmem[0] = a; dmem[1] = b;
                pmem[0]  = w_rr(O_COPY_R, 10'd2, 10'd0);
                pmem[1]  = w_rr(O_ADD_R, 10'd2, 10'd1);
                pmem[2]  = w_rr(O_COPY_R, 10'd3, 10'd0);
                pmem[3]  = w_rr(O_SUB_R, 10'd3, 10'd1);
                pmem[4]  = w_rr(O_COPY_R, 10'd4, 10'd0);
                pmem[5]  = w_rr(O_MUL_R, 10'd4, 10'd1);
                pmem[6]  = w_rr(O_COPY_R, 10'd5, 10'd0);
                pmem[7]  = w_rr(O_CMP, 10'd5, 10'd1);
                pmem[8]  = w_rr(O_NEG, 10'd6, 10'd1);
                pmem[9]  = w_rc(O_COPY_K, 10'd7, a);
                pmem[10] = w_rc(O_ADD_K, 10'd7, b);
                pmem[11] = w_rc(O_COPY_K, 10'd8, a);
                pmem[12] = w_rc(O_SUB_K, 10'd8, b);
                pmem[13] = w_rc(O_COPY_K, 10'd9, a);
                pmem[14] = w_rc(O_MUL_K, 10'd9, b);
                pmem[15] = w_rr(O_COPY_R, 10'h20A, 10'h100);
                self_loop(16);
                run(16);
                c = ($signed(a) < $signed(b)) ? 16'hFFFF : (a == b) ? 16'h0000 : 16'h0001;
                chk("R4 add reg", 32'(dmem[2]), 32'(16'(a + b)));
                chk("R4 sub reg", 32'(dmem[3]), 32'(16'(a - b)));
                chk("R4 mul reg low", 32'(dmem[4]), 32'(16'(a * b)));
                chk("R6 compare", 32'(dmem[5]), 32'(c));
                chk("R4 neg", 32'(dmem[6]), 32'(16'(-b)));
                chk("R5 add const", 32'(dmem[7]), 32'(16'(a + b)));
                chk("R5 sub const", 32'(dmem[8]), 32'(16'(a - b)));
                chk("R5 mul const", 32'(dmem[9]), 32'(16'(a * b)));
                chk("R8 upper pointer bits", 32'(dmem[10]), 32'(a));
                if (i == 0 && j == 0) begin
                    chk("R2 one write per instruction", 32'(wcnt), 16);
                    chk("R3 R11 no flag on valid ops", {30'b0, unimpl, stk_err}, 0);
                end
            end
        end

        // R7 R8: branch sweep, both forms, all conditions
        for (int f = 0; f < 2; f++) begin
            for (int cd = 0; cd < 8; cd++) begin
                for (int xi = 0; xi < 3; xi++) begin
                    for (int ki = 0; ki < 3; ki++) begin
                        logic [15:0] x, k;
                        logic        tk;
                        x = BV[xi]; k = BV[ki];
                        case (cd)
                            0: tk = 1'b1;
                            1: tk = (x == k);
                            2: tk = (x != k);
                            3: tk = ($signed(x) < $signed(k));
                            4: tk = ($signed(x) >= $signed(k));
                            default: tk = 1'b0;
                        endcase
                        clear();
                        dmem[0] = x;
                        if (f == 0) begin
                            pmem[0] = w_rc(O_BR_K, 10'h000, 16'h0);
                            pmem[1] = w_ext(4'(cd), 10'h205, k);
                        end else begin
                            dmem[5] = k;
                            pmem[0] = w_rc(O_BR_R, 10'h300, 16'h0);
                            pmem[1] = w_ext(4'(cd), 10'h005, 16'h0);
                        end
                        pmem[2] = w_rc(O_COPY_K, 10'd9, 16'd1);
                        self_loop(3);
                        pmem[5] = w_rc(O_COPY_K, 10'd9, 16'd2);
                        self_loop(6);
                        run(4);
                        chk($sformatf("R7 branch form %0d cond %0d x=%h k=%h", f, cd, x, k),
                            32'(dmem[9]), tk ? 32'd2 : 32'd1);
                    end
                end
            end
        end

        // R9: nested call and return order
        clear();
        pmem[0]  = w_rr(O_CALL, 10'd10, 10'd0);
        pmem[1]  = w_rc(O_COPY_K, 10'd20, 16'd1);
        self_loop(2);
        pmem[10] = w_rr(O_CALL, 10'h30F, 10'd0);
        pmem[11] = w_rc(O_COPY_K, 10'd21, 16'd2);
        pmem[12] = w_rr(O_RET, 10'd0, 10'd0);
        pmem[15] = w_rc(O_COPY_K, 10'd22, 16'd3);
        pmem[16] = w_rr(O_RET, 10'd0, 10'd0);
        run(8);
        chk("R9 outer return", 32'(dmem[20]), 1);
        chk("R9 inner return", 32'(dmem[21]), 2);
        chk("R9 callee body", 32'(dmem[22]), 3);
        chk("R9 no stack error", 32'(stk_err), 0);

        // R10: overflow after 8 nested calls
        clear();
        pmem[0] = w_rr(O_CALL, 10'd0, 10'd0);
        run(8);
        chk("R10 eight calls fit", 32'(stk_err), 0);
        run(9);
        chk("R10 ninth call overflows", 32'(stk_err), 1);
        run(12);
        chk("R10 error sticky", 32'(stk_err), 1);
        start();
        chk("R1 reset clears stack error", 32'(stk_err), 0);

        // R10: underflow skips to next word
        clear();
        pmem[0] = w_rr(O_RET, 10'd0, 10'd0);
        pmem[1] = w_rc(O_COPY_K, 10'd12, 16'd3);
        self_loop(2);
        run(2);
        chk("R10 underflow flag", 32'(stk_err), 1);
        chk("R10 underflow advances", 32'(dmem[12]), 3);

        // R11: unimplemented opcodes
        for (int u = 0; u < 5; u++) begin
            clear();
            dmem[13] = 16'h0055;
            dmem[0]  = 16'h1111;
            pmem[0] = w_rr(BADOP[u], 10'd13, 10'd0);
            pmem[1] = w_rc(O_COPY_K, 10'd14, 16'd9);
            self_loop(2);
            run(1);
            chk($sformatf("R11 flag op %b", BADOP[u]), 32'(unimpl), 1);
            run(3);
            chk($sformatf("R11 no write op %b", BADOP[u]), 32'(dmem[13]), 32'h0055);
            chk($sformatf("R11 advance op %b", BADOP[u]), 32'(dmem[14]), 9);
            chk($sformatf("R11 sticky op %b", BADOP[u]), 32'(unimpl), 1);
        end

        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end
endmodule